// File: doc/BRIEF.md
# Cascadable Configuration Stream Store

This block is the read side of a one-time-programmable store that feeds a configuration bitstream to a programmable logic device. An internal position counter walks through the stored words. On every qualifying rising clock edge it presents the next item. In serial mode an item is a single bit on `dout[0]`. In byte mode an item is a full byte on `dout[7:0]`. The output is modelled as a value plus a drive flag rather than a tristate pin. When the flag is low, `dout` reads zero.

A single combined reset / output-enable input has a polarity chosen by parameter. When it is asserted, the counter returns to the start and the output is released. An active-low chip enable puts the block in standby. A stall input freezes both the position and the presented data. Once the last stored item has been consumed, the block stops driving and pulls its active-low cascade output low. That output can feed the chip enable of a second instance, so the stream continues seamlessly across a daisy chain.

Stored contents come from an arithmetic pattern, so no memory file is needed. The depth parameter counts stored bytes. It may reach 2,097,152 bytes, which gives the full capacity of 16,777,216 bits, and it is scaled down for simulation.

Top module: `cfg_stream_store`

## Requirements
- R1: On a rising edge where reset is inactive, `ce_n` is low, `busy` is low and the end has not been reached, the position advances by exactly one item.
- R2: With `RST_ACTIVE_HIGH`=1 (default) reset is asserted when `rst_oe`=1; with 0 it is asserted when `rst_oe`=0. While reset is asserted, `dout_en`=0 and `ceo_n`=1, and an edge returns the position to bit 0 of address 0.
- R3: While `ce_n`=1, `dout_en`=0 and the position does not change, whatever the level of `rst_oe` (reset still clears it).
- R4: The terminal count is address `DEPTH`-1. After the final item there has been consumed, the position stays fixed and `dout_en` stays 0 until reset.
- R5: `ceo_n` is 0 exactly when `ce_n`=0, reset is inactive and the terminal count has been passed. Past the end it tracks `ce_n`.
- R6: When output enable drops (reset asserted), `ceo_n` goes to 1. After release it stays 1 until the stream is consumed again from address 0.
- R7: While `busy`=1, the position and the presented data hold. The stream resumes with no item skipped after `busy` returns to 0.
- R8: In serial mode (`OUT_MODE`=MODE_SERIAL), `dout[0]` carries the bit and `dout[7:1]`=0. Bits of each byte are sent MSB first, and the address advances after the eighth bit.
- R9: In byte mode (`OUT_MODE`=MODE_BYTE), one whole byte is presented per item on `dout[7:0]`.
- R10: The byte stored at address a equals (29*a + `SEED`) mod 256. `dout` reads 0 whenever `dout_en`=0.
- R11: With `ceo_n` of one instance wired to `ce_n` of a second instance, the second instance drives its first item in the cycle right after the first instance's last item. The two instances never drive at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising edge active |
| rst_oe | input | 1 | Combined reset / output enable, polarity set by `RST_ACTIVE_HIGH` |
| ce_n | input | 1 | Active-low chip enable |
| busy | input | 1 | Stall: holds position and data while high |
| dout | output | 8 | Output data (bit 0 only in serial mode) |
| dout_en | output | 1 | High when the data output would be driven |
| ceo_n | output | 1 | Active-low cascade enable for the next device |

## Verification
The properties assume that `rst_oe`, `ce_n` and `busy` are synchronous to `clk` and settle well before each rising edge. They also assume that reset is applied at least once before the stream is meaningful, so the checker stays idle until it sees the first reset. The stimulus changes every input one time unit after a rising edge, and samples only on falling edges. For the chained pair, the first instance's `ce_n` is the only free enable, and the second instance's enable comes purely from the first instance's cascade output.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;

    typedef enum logic {
        MODE_SERIAL = 1'b0,
        MODE_BYTE   = 1'b1
    } out_mode_e;

    // Largest supported store, in bits.
    localparam int unsigned FULL_CAPACITY_BITS = 32'd16777216;

    typedef struct packed {
        logic [7:0] data;
        logic       drive;
    } out_bus_t;

    typedef struct packed {
        logic rst_act;
        logic step_en;
        logic drive;
    } ctl_t;

    // Deterministic stored content: (29*a + seed) mod 256.
    function automatic logic [7:0] pattern_byte(input int unsigned a, input logic [7:0] seed);
        return 8'(a * 32'd29 + 32'(seed));
    endfunction

endpackage

// File: rtl/cfg_cascade_ctl.sv
module cfg_cascade_ctl
    import cfg_store_pkg::*;
#(
    parameter bit RST_ACTIVE_HIGH = 1'b1
) (
    input  logic rst_oe,
    input  logic ce_n,
    input  logic busy,
    input  logic past_tc,
    output ctl_t ctl,
    output logic ceo_n
);

    logic oe_on;
    logic ce_on;

    always_comb begin
        ctl.rst_act = RST_ACTIVE_HIGH ? rst_oe : ~rst_oe;
        oe_on       = ~ctl.rst_act;
        ce_on       = ~ce_n;
        ctl.drive   = ce_on & oe_on & ~past_tc;
        ctl.step_en = ce_on & oe_on & ~busy & ~past_tc;
        ceo_n       = ~(ce_on & oe_on & past_tc);
    end

endmodule

// File: rtl/cfg_addr_seq.sv
module cfg_addr_seq
    import cfg_store_pkg::*;
#(
    parameter int        DEPTH    = 64,
    parameter out_mode_e OUT_MODE = MODE_SERIAL,
    localparam int       ADDR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_act,
    input  logic              step_en,
    output logic [ADDR_W-1:0] addr,
    output logic [2:0]        bit_idx,
    output logic              past_tc
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    logic word_done;

    generate
        if (OUT_MODE == MODE_SERIAL) begin : g_serial
            logic [2:0] bit_q;
            always_ff @(posedge clk) begin
                if (rst_act) begin
                    bit_q <= 3'd0;
                end else if (step_en) begin
                    bit_q <= bit_q + 3'd1;
                end
            end
            assign bit_idx   = bit_q;
            assign word_done = (bit_q == 3'd7);
        end else begin : g_byte
            assign bit_idx   = 3'd0;
            assign word_done = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst_act) begin
            addr    <= '0;
            past_tc <= 1'b0;
        end else if (step_en && word_done) begin
            if (addr == LAST_ADDR) begin
                past_tc <= 1'b1;
            end else begin
                addr <= addr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfg_data_path.sv
module cfg_data_path
    import cfg_store_pkg::*;
#(
    parameter int          ADDR_W   = 6,
    parameter out_mode_e   OUT_MODE = MODE_SERIAL,
    parameter logic [7:0]  SEED     = 8'h5A
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        bit_idx,
    input  logic              drive,
    output out_bus_t          bus
);

    logic [7:0] word_v;
    logic       sel_bit;

    always_comb begin
        word_v  = pattern_byte(32'(addr), SEED);
        sel_bit = word_v[3'd7 - bit_idx];
        bus.drive = drive;
        if (!drive) begin
            bus.data = 8'h00;
        end else if (OUT_MODE == MODE_BYTE) begin
            bus.data = word_v;
        end else begin
            bus.data = {7'b0, sel_bit};
        end
    end

endmodule

// File: rtl/cfg_stream_store.sv
module cfg_stream_store
    import cfg_store_pkg::*;
#(
    parameter int         DEPTH           = 64,
    parameter out_mode_e  OUT_MODE        = MODE_SERIAL,
    parameter bit         RST_ACTIVE_HIGH = 1'b1,
    parameter logic [7:0] SEED            = 8'h5A
) (
    input  logic       clk,
    input  logic       rst_oe,
    input  logic       ce_n,
    input  logic       busy,
    output logic [7:0] dout,
    output logic       dout_en,
    output logic       ceo_n
);

    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    ctl_t              ctl;
    out_bus_t          bus;
    logic [ADDR_W-1:0] seq_addr;
    logic [2:0]        seq_bit;
    logic              seq_past;

    cfg_cascade_ctl #(
        .RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)
    ) u_ctl (
        .rst_oe (rst_oe),
        .ce_n   (ce_n),
        .busy   (busy),
        .past_tc(seq_past),
        .ctl    (ctl),
        .ceo_n  (ceo_n)
    );

    cfg_addr_seq #(
        .DEPTH   (DEPTH),
        .OUT_MODE(OUT_MODE)
    ) u_seq (
        .clk    (clk),
        .rst_act(ctl.rst_act),
        .step_en(ctl.step_en),
        .addr   (seq_addr),
        .bit_idx(seq_bit),
        .past_tc(seq_past)
    );

    cfg_data_path #(
        .ADDR_W  (ADDR_W),
        .OUT_MODE(OUT_MODE),
        .SEED    (SEED)
    ) u_dp (
        .addr   (seq_addr),
        .bit_idx(seq_bit),
        .drive  (ctl.drive),
        .bus    (bus)
    );

    assign dout    = bus.data;
    assign dout_en = bus.drive;

endmodule

// File: rtl/cfg_stream_store_chk.sv
module cfg_stream_store_chk #(
    parameter int ADDR_W          = 6,
    parameter bit RST_ACTIVE_HIGH = 1'b1
) (
    input logic              clk,
    input logic              rst_oe,
    input logic              ce_n,
    input logic              busy,
    input logic              dout_en,
    input logic              ceo_n,
    input logic [ADDR_W-1:0] addr,
    input logic [2:0]        bit_idx,
    input logic              past_tc
);

    logic rst_act;
    logic armed = 1'b0;

    assign rst_act = RST_ACTIVE_HIGH ? rst_oe : ~rst_oe;

    always_ff @(posedge clk) begin
        if (rst_act) armed <= 1'b1;
    end

    // R2
    reset_clears_chk: assert property (@(posedge clk) disable iff (!armed)
        rst_act |=> (addr == '0 && bit_idx == 3'd0 && !past_tc));

    // R2
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!armed)
        rst_act |-> (!dout_en && ceo_n));

    // R3
    standby_hold_chk: assert property (@(posedge clk) disable iff (!armed)
        (!rst_act && ce_n) |=> ($stable(addr) && $stable(bit_idx) && $stable(past_tc)));

    // R3
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!armed)
        ce_n |-> !dout_en);

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!armed)
        (!rst_act && busy) |=> ($stable(addr) && $stable(bit_idx) && $stable(past_tc)));

    // R4
    tc_sticky_chk: assert property (@(posedge clk) disable iff (!armed)
        (past_tc && !rst_act) |=> past_tc);

    // R4
    done_quiet_chk: assert property (@(posedge clk) disable iff (!armed)
        past_tc |-> !dout_en);

    // R5
    ceo_excl_chk: assert property (@(posedge clk) disable iff (!armed)
        !ceo_n |-> (!dout_en && !ce_n));

endmodule

bind cfg_stream_store cfg_stream_store_chk #(
    .ADDR_W         (ADDR_W),
    .RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)
) u_chk (
    .clk    (clk),
    .rst_oe (rst_oe),
    .ce_n   (ce_n),
    .busy   (busy),
    .dout_en(dout_en),
    .ceo_n  (ceo_n),
    .addr   (seq_addr),
    .bit_idx(seq_bit),
    .past_tc(seq_past)
);

// File: tb/cfg_stream_store_tb.sv
module cfg_stream_store_tb;
    import cfg_store_pkg::*;

    localparam int         CLK_PERIOD = 10;
    localparam int         DEPTH_T    = 4;
    localparam int         BITS_DEV   = DEPTH_T * 8;
    localparam logic [7:0] SEED_A     = 8'h5A;
    localparam logic [7:0] SEED_B     = 8'hC3;
    localparam logic [7:0] SEED_C     = 8'h3C;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic       rst_a = 1'b1, ce_a = 1'b0, busy_a = 1'b0;
    logic       rst_b = 1'b0, ce_b = 1'b0, busy_b = 1'b0;
    logic [7:0] d1, d2, db;
    logic       en1, en2, enb, ceo1, ceo2, ceob;

    cfg_stream_store #(.DEPTH(DEPTH_T), .OUT_MODE(MODE_SERIAL), .RST_ACTIVE_HIGH(1'b1), .SEED(SEED_A))
    u_dut (.clk(clk), .rst_oe(rst_a), .ce_n(ce_a), .busy(busy_a), .dout(d1), .dout_en(en1), .ceo_n(ceo1));

    cfg_stream_store #(.DEPTH(DEPTH_T), .OUT_MODE(MODE_SERIAL), .RST_ACTIVE_HIGH(1'b1), .SEED(SEED_B))
    u_dut_next (.clk(clk), .rst_oe(rst_a), .ce_n(ceo1), .busy(busy_a), .dout(d2), .dout_en(en2), .ceo_n(ceo2));

    cfg_stream_store #(.DEPTH(DEPTH_T), .OUT_MODE(MODE_BYTE), .RST_ACTIVE_HIGH(1'b0), .SEED(SEED_C))
    u_dut_byte (.clk(clk), .rst_oe(rst_b), .ce_n(ce_b), .busy(busy_b), .dout(db), .dout_en(enb), .ceo_n(ceob));

    typedef struct {
        logic       en;
        logic [7:0] data;
        logic       c1;
        logic       c2;
        logic       enb;
        logic [7:0] db;
        logic       cb;
        string      req;
    } exp_t;

    exp_t sb_q[$];
    int   k = 0;
    int   kb = 0;
    int   checks = 0;
    int   errors = 0;

    function automatic logic [7:0] pat(input int a, input logic [7:0] seed);
        return 8'((a * 29 + int'(seed)) % 256);
    endfunction

    function automatic logic stream_bit(input int idx);
        int dev = idx / BITS_DEV;
        int pos = idx % BITS_DEV;
        logic [7:0] w = pat(pos / 8, (dev == 0) ? SEED_A : SEED_B);
        return w[7 - (pos % 8)];
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of inputs and queues what the outputs must show.
    task automatic step(input logic r, input logic ce, input logic bz,
                        input logic rb, input logic ceb, input logic bzb, input string req);
        exp_t e;
        logic act, actb;
        @(posedge clk);
        #1;
        rst_a = r; ce_a = ce; busy_a = bz;
        rst_b = rb; ce_b = ceb; busy_b = bzb;
        act   = !r && !ce;
        e.en  = act && (k < 2 * BITS_DEV);
        e.data = e.en ? {7'b0, stream_bit(k)} : 8'h00;
        e.c1  = !(act && k >= BITS_DEV);
        e.c2  = !(act && k >= 2 * BITS_DEV);
        actb  = rb && !ceb;
        e.enb = actb && (kb < DEPTH_T);
        e.db  = e.enb ? pat(kb, SEED_C) : 8'h00;
        e.cb  = !(actb && kb >= DEPTH_T);
        e.req = req;
        sb_q.push_back(e);
        if (r) k = 0;
        else if (act && !bz && k < 2 * BITS_DEV) k++;
        if (!rb) kb = 0;
        else if (actb && !bzb && kb < DEPTH_T) kb++;
    endtask

    // Monitor: compares each queued expectation away from the active edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            logic [7:0] bus_v;
            e = sb_q.pop_front();
            bus_v = (en1 ? d1 : 8'h00) | (en2 ? d2 : 8'h00);
            chk({7'b0, en1 | en2}, {7'b0, e.en}, e.req, "chain dout_en");
            chk(bus_v, e.data, e.req, "chain data R8 R10");
            chk({7'b0, en1 & en2}, 8'h00, e.req, "R11 both driving");
            chk({7'b0, ceo1}, {7'b0, e.c1}, e.req, "first ceo_n R5");
            chk({7'b0, ceo2}, {7'b0, e.c2}, e.req, "second ceo_n R11");
            chk({7'b0, enb}, {7'b0, e.enb}, e.req, "byte dout_en R9");
            chk(db, e.db, e.req, "byte data R9 R10");
            chk({7'b0, ceob}, {7'b0, e.cb}, e.req, "byte ceo_n R5");
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R2: reset on both polarities
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, "R2");
        // R1 / R9: stream; byte instance stalls once (R7)
        for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 0, (i == 1), (i == 1) ? "R7" : "R1");
        // R7: stall the serial chain
        step(0, 0, 1, 1, 0, 0, "R7");
        step(0, 0, 1, 1, 0, 0, "R7");
        for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0, 0, "R8");
        // R3: standby
        step(0, 1, 0, 1, 1, 0, "R3");
        step(0, 1, 1, 1, 1, 1, "R3");
        while (k < BITS_DEV - 1) step(0, 0, 0, 1, 0, 0, "R1");
        // R11: hand-off to the second device
        while (k < 2 * BITS_DEV) step(0, 0, 0, 1, 0, 0, "R11");
        // R4: held past the end
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0, "R4");
        // R5: cascade output tracks chip enable past the end
        step(0, 1, 0, 1, 1, 0, "R5");
        step(0, 0, 0, 1, 0, 0, "R5");
        // R6: output enable drops, then stream restarts
        step(1, 0, 0, 0, 0, 0, "R6");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 0, 0, "R6");
        // R2: active-low reset mid-stream on the byte instance
        step(0, 0, 0, 0, 0, 0, "R2");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0, "R2");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule